// File: doc/BRIEF.md
# Pad Ownership and Lock Gate

This block stands between host software and a bank of per-pad configuration registers. For every pad it keeps a 4-bit ownership field, a host-mode bit and two lock bits: a configuration lock and a transmit-only lock. From these it decides whether a host write aimed at one pad, or at a whole pad group, may take effect. It answers every request with a one-cycle grant or a one-cycle reject. The configuration bank uses the grant as its write enable, so a rejected write leaves that bank unchanged.

The ownership, host-mode and lock words are changed only through a separate privileged write strobe. A read strobe returns any of them, and reads are never refused. The block also filters raw per-pad events. An event reaches the status logic only while the pad is in host mode. A pad left in firmware mode keeps working as plain I/O, but its status bit is never set.

The default build has 40 pads in groups of 16, so the last group is partial. Word addresses are: ownership words 0 to 4, host-mode words 5 to 7, lock words 8 to 13. Addresses 14 and 15 are unmapped.

Top module: `pad_gate`

## Requirements
- R1: After synchronous reset every ownership word reads 0, every host-mode word reads all ones in its low GROUP_PADS bits (0x0000FFFF by default), every lock word reads 0, and every in-range pad request is granted.
- R2: A single-pad request on `req_idx` with `req_group`=0 produces, one cycle later, `req_grant`=1 exactly when the pad is host-owned and unlocked, and otherwise `req_reject`=1.
- R3: Pad p's ownership field is bits [(p mod 8)*4 +: 4] of ownership word p/8 (word address p/8). The pad is host-owned only when all four bits are 0; any nonzero value in any bit position makes it unusable.
- R4: For group g, word address LOCK_BASE+2g holds the configuration-lock bits and LOCK_BASE+2g+1 holds the TX-lock bits, with bit p mod GROUP_PADS belonging to pad p. A pad counts as unlocked only when both of its bits are 0.
- R5: A group request (`req_group`=1, `req_idx`=g) is granted only if every existing pad of group g is usable; one failing pad rejects the whole group. Lock or ownership bits of pad positions beyond NUM_PADS in a partial group have no effect.
- R6: Each request gets exactly one response, one cycle later: a single-cycle pulse on either `req_grant` or `req_reject`, never both. Nothing is pulsed without a request. A pad index ≥ NUM_PADS or a group index ≥ the number of groups is rejected.
- R7: `cfg_rd_en` loads `cfg_rdata` one cycle later with the addressed word, and `cfg_rdata` holds that value while no read is issued. Unmapped addresses read 0, and a write to them changes no register.
- R8: `evt_gated[p]` equals `evt_raw[p]` AND pad p's host-mode bit (host-mode word address HOST_BASE+p/GROUP_PADS, bit p mod GROUP_PADS), registered by one cycle. Host mode does not affect write grants.
- R9: A privileged write takes effect at the clock edge on which it is issued. A request or read in that same cycle sees the old state, and one in the next cycle sees the new state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Privileged write strobe for ownership, host-mode and lock words |
| cfg_rd_en | input | 1 | Read strobe |
| cfg_addr | input | ADDR_W | Word address |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Registered read data |
| req_valid | input | 1 | Host write request to pad configuration |
| req_group | input | 1 | 1: request covers the whole group `req_idx`; 0: a single pad |
| req_idx | input | IDX_W | Pad index or group index |
| req_grant | output | 1 | One-cycle pulse: write may take effect |
| req_reject | output | 1 | One-cycle pulse: write refused |
| evt_raw | input | NUM_PADS | Raw per-pad event indications |
| evt_gated | output | NUM_PADS | Events allowed to set status bits |

## Verification
Every result is due exactly one clock after its cause. Grant and reject follow the request cycle, read data follows the read strobe, and gated events follow the raw events. A privileged write is seen by requests and reads from the next cycle on. The bench drives inputs at the falling edge. In that same step its behavioural model computes the outputs the next rising edge must produce and only then applies the write. The comparison is made at the following falling edge, so same-cycle write and request cases are checked against the old state by construction of the timing, not by luck.

// File: rtl/pad_gate_pkg.sv
package pad_gate_pkg;

  localparam int WORD_W          = 32;
  localparam int OWN_FIELD_W     = 4;
  localparam int FIELDS_PER_WORD = WORD_W / OWN_FIELD_W;
  localparam int MAX_GROUP_PADS  = 32;

  typedef enum logic [1:0] {
    KIND_OWN  = 2'd0,
    KIND_HOST = 2'd1,
    KIND_LOCK = 2'd2,
    KIND_NONE = 2'd3
  } reg_kind_e;

endpackage

// File: rtl/pad_gate_regs.sv
module pad_gate_regs
  import pad_gate_pkg::*;
#(
  parameter int NUM_PADS   = 40,
  parameter int GROUP_PADS = 16,
  parameter int NOWN       = 5,
  parameter int NGRP       = 3,
  parameter int ADDR_W     = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   wdata,
  output logic [WORD_W-1:0]   rdata,
  output logic [NUM_PADS-1:0] pad_owned,
  output logic [NUM_PADS-1:0] pad_unlocked,
  output logic [NUM_PADS-1:0] pad_hostmode
);

  localparam int HOST_BASE = NOWN;
  localparam int LOCK_BASE = NOWN + NGRP;
  localparam int END_ADDR  = NOWN + 3 * NGRP;
  localparam int OWN_IW    = (NOWN > 1) ? $clog2(NOWN) : 1;
  localparam int GRP_IW    = (NGRP > 1) ? $clog2(NGRP) : 1;

  logic [WORD_W-1:0]     own_q   [NOWN];
  logic [GROUP_PADS-1:0] host_q  [NGRP];
  logic [GROUP_PADS-1:0] cfglk_q [NGRP];
  logic [GROUP_PADS-1:0] txlk_q  [NGRP];

  reg_kind_e         kind;
  logic [ADDR_W-1:0] off;
  logic [OWN_IW-1:0] own_idx;
  logic [GRP_IW-1:0] grp_idx;
  logic              lock_tx;

  // address decode
  always_comb begin
    kind = KIND_NONE;
    off  = '0;
    if (32'(addr) < 32'(HOST_BASE)) begin
      kind = KIND_OWN;
      off  = addr;
    end else if (32'(addr) < 32'(LOCK_BASE)) begin
      kind = KIND_HOST;
      off  = addr - ADDR_W'(HOST_BASE);
    end else if (32'(addr) < 32'(END_ADDR)) begin
      kind = KIND_LOCK;
      off  = addr - ADDR_W'(LOCK_BASE);
    end
  end

  assign own_idx = off[OWN_IW-1:0];
  assign lock_tx = off[0];
  assign grp_idx = (kind == KIND_LOCK) ? off[GRP_IW:1] : off[GRP_IW-1:0];

  // privileged write path
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NOWN; i++) own_q[i] <= '0;
      for (int g = 0; g < NGRP; g++) begin
        host_q[g]  <= '1;
        cfglk_q[g] <= '0;
        txlk_q[g]  <= '0;
      end
    end else if (wr_en) begin
      case (kind)
        KIND_OWN:  own_q[own_idx]  <= wdata;
        KIND_HOST: host_q[grp_idx] <= wdata[GROUP_PADS-1:0];
        KIND_LOCK: begin
          if (lock_tx) txlk_q[grp_idx]  <= wdata[GROUP_PADS-1:0];
          else         cfglk_q[grp_idx] <= wdata[GROUP_PADS-1:0];
        end
        default: ;
      endcase
    end
  end

  // registered read path, holds between reads
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (kind)
        KIND_OWN:  rdata <= own_q[own_idx];
        KIND_HOST: rdata <= WORD_W'(host_q[grp_idx]);
        KIND_LOCK: rdata <= lock_tx ? WORD_W'(txlk_q[grp_idx])
                                    : WORD_W'(cfglk_q[grp_idx]);
        default:   rdata <= '0;
      endcase
    end
  end

  // per-pad state unpacking
  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    localparam int WI = p / FIELDS_PER_WORD;
    localparam int SH = (p % FIELDS_PER_WORD) * OWN_FIELD_W;
    localparam int GI = p / GROUP_PADS;
    localparam int BI = p % GROUP_PADS;
    assign pad_owned[p]    = (own_q[WI][SH +: OWN_FIELD_W] == '0);
    assign pad_unlocked[p] = !(cfglk_q[GI][BI] || txlk_q[GI][BI]);
    assign pad_hostmode[p] = host_q[GI][BI];
  end

  // R7: reads of unmapped addresses return zero
  p_unmapped_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && kind == KIND_NONE) |=> (rdata == '0));

  // R7: read data is held between read strobes
  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

endmodule

// File: rtl/pad_gate_access.sv
module pad_gate_access #(
  parameter int NUM_PADS   = 40,
  parameter int GROUP_PADS = 16,
  parameter int NGRP       = 3,
  parameter int IDX_W      = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_group,
  input  logic [IDX_W-1:0]    req_idx,
  input  logic [NUM_PADS-1:0] pad_ok,
  output logic                grant,
  output logic                reject
);

  logic [NGRP-1:0] grp_ok;
  logic            allow;

  // one AND tree per group; absent positions of a partial group count as usable
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic [GROUP_PADS-1:0] bits;
    for (genvar i = 0; i < GROUP_PADS; i++) begin : g_bit
      if (g * GROUP_PADS + i < NUM_PADS) begin : g_real
        assign bits[i] = pad_ok[g * GROUP_PADS + i];
      end else begin : g_pad_fill
        assign bits[i] = 1'b1;
      end
    end
    assign grp_ok[g] = &bits;
  end

  always_comb begin
    allow = 1'b0;
    if (req_group) begin
      for (int g = 0; g < NGRP; g++)
        if (32'(req_idx) == 32'(g)) allow = grp_ok[g];
    end else begin
      for (int p = 0; p < NUM_PADS; p++)
        if (32'(req_idx) == 32'(p)) allow = pad_ok[p];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant  <= 1'b0;
      reject <= 1'b0;
    end else begin
      grant  <= req_valid && allow;
      reject <= req_valid && !allow;
    end
  end

endmodule

// File: rtl/pad_gate_event.sv
module pad_gate_event #(
  parameter int NUM_PADS = 40
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PADS-1:0] evt_raw,
  input  logic [NUM_PADS-1:0] hostmode,
  output logic [NUM_PADS-1:0] evt_gated
);

  always_ff @(posedge clk) begin
    if (rst) evt_gated <= '0;
    else     evt_gated <= evt_raw & hostmode;
  end

  // R8: a pad in firmware mode never passes an event
  p_fw_silent_r8: assert property (@(posedge clk) disable iff (rst)
    ((evt_gated & ~$past(hostmode)) == '0));

endmodule

// File: rtl/pad_gate.sv
module pad_gate
  import pad_gate_pkg::*;
#(
  parameter int NUM_PADS   = 40,
  parameter int GROUP_PADS = 16,
  localparam int NOWN      = (NUM_PADS + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD,
  localparam int NGRP      = (NUM_PADS + GROUP_PADS - 1) / GROUP_PADS,
  localparam int NWORDS    = NOWN + 3 * NGRP,
  localparam int ADDR_W    = $clog2(NWORDS),
  localparam int IDX_W     = (NUM_PADS > 1) ? $clog2(NUM_PADS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_wr_en,
  input  logic                cfg_rd_en,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [WORD_W-1:0]   cfg_wdata,
  output logic [WORD_W-1:0]   cfg_rdata,
  input  logic                req_valid,
  input  logic                req_group,
  input  logic [IDX_W-1:0]    req_idx,
  output logic                req_grant,
  output logic                req_reject,
  input  logic [NUM_PADS-1:0] evt_raw,
  output logic [NUM_PADS-1:0] evt_gated
);

  logic [NUM_PADS-1:0] pad_owned;
  logic [NUM_PADS-1:0] pad_unlocked;
  logic [NUM_PADS-1:0] pad_hostmode;
  logic [NUM_PADS-1:0] pad_usable;

  pad_gate_regs #(
    .NUM_PADS  (NUM_PADS),
    .GROUP_PADS(GROUP_PADS),
    .NOWN      (NOWN),
    .NGRP      (NGRP),
    .ADDR_W    (ADDR_W)
  ) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (cfg_wr_en),
    .rd_en       (cfg_rd_en),
    .addr        (cfg_addr),
    .wdata       (cfg_wdata),
    .rdata       (cfg_rdata),
    .pad_owned   (pad_owned),
    .pad_unlocked(pad_unlocked),
    .pad_hostmode(pad_hostmode)
  );

  assign pad_usable = pad_owned & pad_unlocked;

  pad_gate_access #(
    .NUM_PADS  (NUM_PADS),
    .GROUP_PADS(GROUP_PADS),
    .NGRP      (NGRP),
    .IDX_W     (IDX_W)
  ) u_access (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_group(req_group),
    .req_idx  (req_idx),
    .pad_ok   (pad_usable),
    .grant    (req_grant),
    .reject   (req_reject)
  );

  pad_gate_event #(
    .NUM_PADS(NUM_PADS)
  ) u_event (
    .clk      (clk),
    .rst      (rst),
    .evt_raw  (evt_raw),
    .hostmode (pad_hostmode),
    .evt_gated(evt_gated)
  );

  // R6: grant and reject never coincide
  p_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(req_grant && req_reject));

  // R6: each request gets exactly one response in the next cycle
  p_one_resp_r6: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> (req_grant ^ req_reject));

  // R6: no response without a request
  p_no_spurious_r6: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !(req_grant || req_reject));

endmodule

// File: tb/sim_pad_gate.sv
module sim_pad_gate;

  localparam int NP = 40;
  localparam int GP = 16;
  localparam int NO = 5;
  localparam int NG = 3;
  localparam int HOST_BASE = NO;
  localparam int LOCK_BASE = NO + NG;
  localparam int END_ADDR  = NO + 3 * NG;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_wr_en = 1'b0;
  logic          cfg_rd_en = 1'b0;
  logic [3:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic [31:0]   cfg_rdata;
  logic          req_valid = 1'b0;
  logic          req_group = 1'b0;
  logic [5:0]    req_idx = '0;
  logic          req_grant;
  logic          req_reject;
  logic [NP-1:0] evt_raw = '0;
  logic [NP-1:0] evt_gated;

  always #5 clk = ~clk;

  pad_gate #(.NUM_PADS(NP), .GROUP_PADS(GP)) u0 (
    .clk(clk), .rst(rst),
    .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_group(req_group), .req_idx(req_idx),
    .req_grant(req_grant), .req_reject(req_reject),
    .evt_raw(evt_raw), .evt_gated(evt_gated)
  );

  // behavioural reference state
  logic [31:0]   own_m  [NO];
  logic [GP-1:0] host_m [NG];
  logic [GP-1:0] cfg_m  [NG];
  logic [GP-1:0] tx_m   [NG];

  logic          exp_grant, exp_reject;
  logic [31:0]   exp_rdata;
  logic [NP-1:0] exp_evt;

  int    n_checks = 0;
  int    n_errors = 0;
  string tag = "R1";
  bit    finished = 1'b0;

  function automatic bit usable_m(int p);
    logic [3:0] fld;
    fld = 4'((own_m[p / 8] >> ((p % 8) * 4)) & 32'hF);
    return (fld == 4'd0) && !cfg_m[p / GP][p % GP] && !tx_m[p / GP][p % GP];
  endfunction

  function automatic bit allow_m(bit grp, int idx);
    bit ok;
    if (grp) begin
      if (idx >= NG) return 1'b0;
      ok = 1'b1;
      for (int i = 0; i < GP; i++)
        if (idx * GP + i < NP && !usable_m(idx * GP + i)) ok = 1'b0;
      return ok;
    end
    if (idx >= NP) return 1'b0;
    return usable_m(idx);
  endfunction

  function automatic logic [31:0] read_m(int a);
    int o;
    if (a < HOST_BASE) return own_m[a];
    if (a < LOCK_BASE) return 32'(host_m[a - HOST_BASE]);
    if (a < END_ADDR) begin
      o = a - LOCK_BASE;
      return (o % 2 == 1) ? 32'(tx_m[o / 2]) : 32'(cfg_m[o / 2]);
    end
    return 32'h0;
  endfunction

  task automatic cmp(string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, predict, then compare at the next falling edge
  task automatic step(bit wr, bit rd, int addr, logic [31:0] wd,
                      bit rv, bit rg, int idx, logic [NP-1:0] ev);
    logic [NP-1:0] hv;
    int o;
    cfg_wr_en = wr; cfg_rd_en = rd; cfg_addr = 4'(addr); cfg_wdata = wd;
    req_valid = rv; req_group = rg; req_idx = 6'(idx); evt_raw = ev;
    exp_grant  = rv && allow_m(rg, idx);
    exp_reject = rv && !allow_m(rg, idx);
    if (rd) exp_rdata = read_m(addr);
    for (int p = 0; p < NP; p++) hv[p] = host_m[p / GP][p % GP];
    exp_evt = ev & hv;
    if (wr) begin
      if (addr < HOST_BASE) own_m[addr] = wd;
      else if (addr < LOCK_BASE) host_m[addr - HOST_BASE] = wd[GP-1:0];
      else if (addr < END_ADDR) begin
        o = addr - LOCK_BASE;
        if (o % 2 == 1) tx_m[o / 2] = wd[GP-1:0];
        else            cfg_m[o / 2] = wd[GP-1:0];
      end
    end
    @(negedge clk);
    cmp("grant",  64'(req_grant),  64'(exp_grant));
    cmp("reject", 64'(req_reject), 64'(exp_reject));
    cmp("rdata",  64'(cfg_rdata),  64'(exp_rdata));
    cmp("events", 64'(evt_gated),  64'(exp_evt));
  endtask

  task automatic wr(int a, logic [31:0] d);
    step(1, 0, a, d, 0, 0, 0, '0);
  endtask
  task automatic rd(int a);
    step(0, 1, a, 32'h0, 0, 0, 0, '0);
  endtask
  task automatic pad(int p);
    step(0, 0, 0, 32'h0, 1, 0, p, '0);
  endtask
  task automatic grp(int g);
    step(0, 0, 0, 32'h0, 1, 1, g, '0);
  endtask

  initial begin
    for (int i = 0; i < NO; i++) own_m[i] = '0;
    for (int g = 0; g < NG; g++) begin
      host_m[g] = '1; cfg_m[g] = '0; tx_m[g] = '0;
    end
    exp_grant = 0; exp_reject = 0; exp_rdata = '0; exp_evt = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset contents and all pads usable
    tag = "R1";
    for (int a = 0; a < END_ADDR; a++) rd(a);
    for (int p = 0; p < NP; p++) pad(p);
    for (int g = 0; g < NG; g++) grp(g);

    // R3: ownership field packing, each bit of a field blocks on its own
    tag = "R3";
    for (int b = 0; b < 4; b++) begin
      wr(2, 32'h1 << (8 + b));        // pad 18 field
      pad(17); pad(18); pad(19);
    end
    wr(2, 32'h8000_0000);             // top field of word 2: pad 23
    pad(22); pad(23); pad(24);
    rd(2);
    wr(2, 32'h0);
    tag = "R2";
    pad(18); pad(23);

    // R4: configuration-lock and TX-lock words per group
    tag = "R4";
    wr(LOCK_BASE + 2, 32'h8);         // group 1 cfg lock, pad 19
    pad(19); pad(18); rd(LOCK_BASE + 2);
    wr(LOCK_BASE + 2, 32'h0);
    wr(LOCK_BASE + 3, 32'h8);         // group 1 tx lock, pad 19
    pad(19); rd(LOCK_BASE + 3);

    // R5: group checks, partial group padding
    tag = "R5";
    grp(1); grp(0); grp(2);
    wr(LOCK_BASE + 3, 32'h0);
    grp(1);
    wr(LOCK_BASE + 4, 32'h0000_1000); // pad 44 does not exist
    grp(2);
    wr(LOCK_BASE + 5, 32'h0000_0080); // pad 39, last real pad
    grp(2); pad(39);
    wr(LOCK_BASE + 5, 32'h0);
    wr(4, 32'h0000_0F00);             // word 4 fields cover 32..39: pad 34
    grp(2);
    wr(4, 32'h0);

    // R6: out-of-range indices and idle cycles
    tag = "R6";
    pad(40); pad(63); grp(3); grp(63);
    step(0, 0, 0, 32'h0, 0, 0, 5, '0);

    // R7: unmapped reads and writes, hold between reads
    tag = "R7";
    rd(0);
    wr(14, 32'hFFFF_FFFF); wr(15, 32'hFFFF_FFFF);
    rd(14); rd(15);
    for (int a = 0; a < END_ADDR; a++) rd(a);
    step(0, 0, 0, 32'h0, 0, 0, 0, '0);
    pad(0);

    // R8: host mode gates events, not grants
    tag = "R8";
    step(0, 0, 0, 32'h0, 0, 0, 0, '1);
    wr(HOST_BASE, 32'hFFFF_FFFE);
    step(0, 0, 0, 32'h0, 1, 0, 0, '1);
    wr(HOST_BASE + 2, 32'h0);
    step(0, 0, 0, 32'h0, 1, 1, 2, '1);
    rd(HOST_BASE); rd(HOST_BASE + 2);

    // R9: same-cycle write sees old state
    tag = "R9";
    step(1, 1, LOCK_BASE, 32'h20, 1, 0, 5, '1);
    step(0, 1, LOCK_BASE, 32'h0, 1, 0, 5, '1);
    step(1, 0, LOCK_BASE, 32'h0, 1, 1, 0, '0);
    grp(0);

    // R2: mixed random traffic against the model
    tag = "R2";
    for (int n = 0; n < 400; n++) begin
      logic [31:0] d;
      int a;
      a = int'($urandom_range(0, 15));
      d = (a < HOST_BASE) ? (32'h1 << $urandom_range(0, 31)) & {32{$urandom_range(0, 3) == 0}}
                          : $urandom & $urandom & $urandom;
      if (a >= HOST_BASE && a < LOCK_BASE && $urandom_range(0, 1) == 1) d = 32'hFFFF;
      step($urandom_range(0, 3) == 0, $urandom_range(0, 1) == 1, a, d,
           $urandom_range(0, 3) != 0, $urandom_range(0, 3) == 0,
           int'($urandom_range(0, 45)), {$urandom, $urandom});
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog %s actual=hung expected=done", tag);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule